// File: doc/BRIEF.md
# Stop-Release Bus-Busy Guard

This controller sits next to a distributed bus arbiter. Several arbiters share one stop line. When that line is released, they can fall out of step with each other. The guard prevents this by holding the shared busy line in a known pattern around every stop.

The guard receives the system-wide stop indication and delays it by a fixed number of cycles. It also watches the shared active-low busy input. Once a stop has been seen, the guard waits for one cycle in which the busy input is idle. It then forces the busy line through a fixed run of cycles. It keeps forcing it for as long as the delayed stop remains active.

The guard also drives:
- a local active-low stop-activate output;
- an active-low bus-busy indication, which stays asserted for a few cycles after every stop-activate cycle;
- a debug copy of its state counter.

A mode input chooses between two behaviours. With the full workaround, the guard runs the sequence above. As a plain follower, it only tracks the delayed stop.

Top module: `stop_guard`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) forces the state to 0, clears the delay line and clears the hold counter. While `forceStop` and `forceBusy` are low, all three active-low outputs then read 1.
- R2: `stopIn` takes effect exactly 3 clock edges after it is sampled. From state 0, the state becomes 1 at the edge where the delayed stop is high.
- R3: In workaround mode (`workaroundEn`=1), state 1 moves to state 2 only at an edge where `busyInN` is 1. While `busyInN` is 0, it stays in state 1.
- R4: In workaround mode, states 2 through 7 each advance by one at every edge, whatever the other inputs are.
- R5: In workaround mode, state 8 returns to 0 only at an edge where the delayed stop is low. Otherwise it remains 8.
- R6: In follower mode (`workaroundEn`=0), state 1 returns to 0 at the first edge where the delayed stop is low. From 0 or 1, the state never goes above 1.
- R7: `stopActN` is 0 exactly when `forceStop` is 1 or the state is nonzero.
- R8: `busyOutN` is 0 exactly when the state is 3 or higher. Each such run therefore lasts at least 6 consecutive cycles unless a reset cuts it short.
- R9: `busBusyN` is 0 in the following cases:
  - in every cycle where `stopActN` is 0;
  - in each of the 5 cycles after such a cycle, unless a reset clears the hold counter first;
  - in every cycle where `forceBusy` is 1.

  Otherwise it is 1.
- R10: `stateDbg` shows the state counter as an unsigned binary value from 0 to 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| stopIn | input | 1 | System-wide stop indication, active high, before delay |
| busyInN | input | 1 | Shared bus busy line, active low |
| workaroundEn | input | 1 | 1 selects the full workaround, 0 selects the plain stop follower |
| forceStop | input | 1 | Forces the local stop-activate output |
| forceBusy | input | 1 | Forces the bus-busy indication |
| stopActN | output | 1 | Local stop-activate, active low |
| busyOutN | output | 1 | Drive onto the shared busy line, active low |
| busBusyN | output | 1 | Bus-busy hold indication, active low |
| stateDbg | output | STATE_W (4) | Current state counter value |

## Verification
The stimulus targets the points where a wrong design would diverge from the model:
- **Busy input held low while the guard sits in state 1.** A design that ignored the busy input would force the bus too early.
- **A stop that ends during the forced run, and a stop that outlasts it.** A design that left state 8 too early would give a short busy window. One that never left would lock the bus.
- **The tail of the bus-busy hold.** An off-by-one here shows up as a cycle too many or too few of `busBusyN` low.
- **Follower mode, a reset in the middle of a sequence, and a long random phase that toggles the mode.** Any slip in the three-edge stop delay or in the transition conditions shifts the state trace by a cycle.

// File: rtl/stop_guard_pkg.sv
package stop_guard_pkg;

  // Strobes from the control FSM to the datapath.
  typedef struct packed {
    logic stopActive;  // local stop-activate is asserted this cycle
    logic busyDrive;   // shared busy line is being forced this cycle
  } guardStrobes_t;

endpackage

// File: rtl/stop_guard_dp.sv
module stop_guard_dp
  import stop_guard_pkg::*;
#(
  parameter int STOP_DELAY  = 3,
  parameter int HOLD_CYCLES = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          stopIn,
  input  logic          forceBusy,
  input  guardStrobes_t strobes,
  output logic          stopLate,
  output logic          busBusyN
);

  localparam int HC_W = $clog2(HOLD_CYCLES + 1);
  localparam logic [HC_W-1:0] HOLD_LOAD = HC_W'(HOLD_CYCLES - 1);

  // Delay line for the system-wide stop indication.
  generate
    if (STOP_DELAY == 0) begin : g_noDelay
      assign stopLate = stopIn;
    end else begin : g_delay
      logic [STOP_DELAY-1:0] stage;
      for (genvar i = 0; i < STOP_DELAY; i++) begin : g_stage
        always_ff @(posedge clk) begin
          if (rst) begin
            stage[i] <= 1'b0;
          end else if (i == 0) begin
            stage[i] <= stopIn;
          end else begin
            stage[i] <= stage[(i == 0) ? 0 : i-1];
          end
        end
      end
      assign stopLate = stage[STOP_DELAY-1];
    end
  endgenerate

  // Hold counter: reloaded on every stop-activate cycle, counts down to zero.
  logic [HC_W-1:0] holdCnt;
  logic            holdActive;

  always_ff @(posedge clk) begin
    if (rst) begin
      holdCnt <= '0;
    end else if (strobes.stopActive) begin
      holdCnt <= HOLD_LOAD;
    end else if (holdActive) begin
      holdCnt <= holdCnt - HC_W'(1);
    end
  end

  assign holdActive = (holdCnt != '0);
  assign busBusyN   = ~(forceBusy | strobes.stopActive | holdActive);

endmodule

// File: rtl/stop_guard_ctrl.sv
module stop_guard_ctrl
  import stop_guard_pkg::*;
#(
  parameter int FORCE_STEPS = 6,
  parameter int STATE_W     = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               stopLate,
  input  logic               busyInN,
  input  logic               workaroundEn,
  input  logic               forceStop,
  output guardStrobes_t      strobes,
  output logic [STATE_W-1:0] stateQ
);

  localparam logic [STATE_W-1:0] ST_IDLE  = STATE_W'(0);
  localparam logic [STATE_W-1:0] ST_WAIT  = STATE_W'(1);
  localparam logic [STATE_W-1:0] ST_FORCE = STATE_W'(2);
  localparam logic [STATE_W-1:0] ST_LAST  = STATE_W'(FORCE_STEPS + 2);

  logic [STATE_W-1:0] stateD;

  always_comb begin
    stateD = stateQ;
    if (stateQ == ST_IDLE) begin
      if (stopLate) stateD = ST_WAIT;
    end else if (stateQ == ST_WAIT) begin
      if (workaroundEn) begin
        if (busyInN) stateD = ST_FORCE;
      end else if (!stopLate) begin
        stateD = ST_IDLE;
      end
    end else if (stateQ == ST_LAST) begin
      if (workaroundEn && !stopLate) stateD = ST_IDLE;
    end else if (workaroundEn) begin
      stateD = stateQ + STATE_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) stateQ <= ST_IDLE;
    else     stateQ <= stateD;
  end

  always_comb begin
    strobes.stopActive = forceStop | (stateQ != ST_IDLE);
    strobes.busyDrive  = (stateQ > ST_FORCE);
  end

endmodule

// File: rtl/stop_guard.sv
module stop_guard
  import stop_guard_pkg::*;
#(
  parameter int STOP_DELAY  = 3,
  parameter int HOLD_CYCLES = 6,
  parameter int FORCE_STEPS = 6,
  localparam int STATE_W    = $clog2(FORCE_STEPS + 3)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               stopIn,
  input  logic               busyInN,
  input  logic               workaroundEn,
  input  logic               forceStop,
  input  logic               forceBusy,
  output logic               stopActN,
  output logic               busyOutN,
  output logic               busBusyN,
  output logic [STATE_W-1:0] stateDbg
);

  guardStrobes_t strobes;
  logic          stopLate;

  stop_guard_ctrl #(
    .FORCE_STEPS(FORCE_STEPS),
    .STATE_W    (STATE_W)
  ) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .stopLate    (stopLate),
    .busyInN     (busyInN),
    .workaroundEn(workaroundEn),
    .forceStop   (forceStop),
    .strobes     (strobes),
    .stateQ      (stateDbg)
  );

  stop_guard_dp #(
    .STOP_DELAY (STOP_DELAY),
    .HOLD_CYCLES(HOLD_CYCLES)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .stopIn   (stopIn),
    .forceBusy(forceBusy),
    .strobes  (strobes),
    .stopLate (stopLate),
    .busBusyN (busBusyN)
  );

  assign stopActN = ~strobes.stopActive;
  assign busyOutN = ~strobes.busyDrive;

endmodule

// File: rtl/stop_guard_chk.sv
module stop_guard_chk #(
  parameter int FORCE_STEPS = 6,
  parameter int STATE_W     = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               stopLate,
  input logic               busyInN,
  input logic               workaroundEn,
  input logic               stopActN,
  input logic               busyOutN,
  input logic               busBusyN,
  input logic [STATE_W-1:0] stateDbg
);

  localparam logic [STATE_W-1:0] LAST = STATE_W'(FORCE_STEPS + 2);

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (stateDbg == '0));  // R1

  AST_STOP_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (stateDbg == '0 && stopLate) |=> (stateDbg == STATE_W'(1)));  // R2

  AST_WAIT_BUSY: assert property (@(posedge clk) disable iff (rst)
    (workaroundEn && stateDbg == STATE_W'(1) && !busyInN) |=> (stateDbg == STATE_W'(1)));  // R3

  AST_FORCE_STEP: assert property (@(posedge clk) disable iff (rst)
    (workaroundEn && stateDbg >= STATE_W'(2) && stateDbg < LAST)
      |=> (stateDbg == $past(stateDbg) + STATE_W'(1)));  // R4

  AST_LAST_HOLD: assert property (@(posedge clk) disable iff (rst)
    (stateDbg == LAST && stopLate) |=> (stateDbg == LAST));  // R5

  AST_FOLLOW_CAP: assert property (@(posedge clk) disable iff (rst)
    (!workaroundEn && stateDbg <= STATE_W'(1)) |=> (stateDbg <= STATE_W'(1)));  // R6

  AST_STOPACT_STATE: assert property (@(posedge clk) disable iff (rst)
    (stateDbg != '0) |-> !stopActN);  // R7

  AST_BUSY_START: assert property (@(posedge clk) disable iff (rst)
    (workaroundEn && stateDbg == STATE_W'(2)) |=> !busyOutN);  // R8

  AST_HOLD_TAIL: assert property (@(posedge clk) disable iff (rst)
    !stopActN |=> !busBusyN);  // R9

endmodule

bind stop_guard stop_guard_chk #(
  .FORCE_STEPS(FORCE_STEPS),
  .STATE_W    (STATE_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .stopLate    (stopLate),
  .busyInN     (busyInN),
  .workaroundEn(workaroundEn),
  .stopActN    (stopActN),
  .busyOutN    (busyOutN),
  .busBusyN    (busBusyN),
  .stateDbg    (stateDbg)
);

// File: tb/stop_guard_tb.sv
module stop_guard_tb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stopIn = 1'b0;
  logic busyInN = 1'b1;
  logic workaroundEn = 1'b1;
  logic forceStop = 1'b0;
  logic forceBusy = 1'b0;
  logic stopActN, busyOutN, busBusyN;
  logic [3:0] stateDbg;

  always #5 clk = ~clk;

  stop_guard u_dut (
    .clk(clk), .rst(rst), .stopIn(stopIn), .busyInN(busyInN),
    .workaroundEn(workaroundEn), .forceStop(forceStop), .forceBusy(forceBusy),
    .stopActN(stopActN), .busyOutN(busyOutN), .busBusyN(busBusyN),
    .stateDbg(stateDbg)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit finished = 0;

  // Behavioural reference model.
  int    mState = 0;
  int    deadline = -1;
  bit    stopQ[$] = '{1'b0, 1'b0, 1'b0};
  string stTag = "R1";
  int    busyRun = 0;
  bit    runCut = 0;

  function automatic void chk(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endfunction

  task automatic step();
    bit expStop, expBusy, expBus, late;
    @(negedge clk);
    expStop = forceStop || (mState != 0);
    expBusy = (mState > 2);
    expBus  = forceBusy || expStop || (cyc < deadline);
    chk({"R10/", stTag}, int'(stateDbg), mState, "state");
    chk(rst ? "R1" : "R7", int'(stopActN), int'(!expStop), "stopActN");
    chk("R8", int'(busyOutN), int'(!expBusy), "busyOutN");
    chk("R9", int'(busBusyN), int'(!expBus), "busBusyN");
    // Minimum busy window (R8)
    if (!busyOutN) begin
      busyRun++;
      if (rst) runCut = 1;
    end else if (busyRun > 0) begin
      if (!runCut) chk("R8", int'(busyRun >= 6), 1, "busy window at least 6");
      busyRun = 0;
      runCut = 0;
    end
    @(posedge clk);
    if (rst) begin
      mState = 0;
      deadline = -1;
      stopQ = '{1'b0, 1'b0, 1'b0};
      stTag = "R1";
    end else begin
      if (expStop) deadline = cyc + 6;
      late = stopQ.pop_front();
      stopQ.push_back(stopIn);
      if (mState == 0) begin
        stTag = "R2";
        if (late) mState = 1;
      end else if (mState == 1 && workaroundEn) begin
        stTag = "R3";
        if (busyInN) mState = 2;
      end else if (mState == 1) begin
        stTag = "R6";
        if (!late) mState = 0;
      end else if (mState == 8) begin
        stTag = "R5";
        if (workaroundEn && !late) mState = 0;
      end else if (workaroundEn) begin
        stTag = "R4";
        mState = mState + 1;
      end else begin
        stTag = "R6";
      end
    end
    cyc++;
    #1;
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state, with forces active, then inactive
    forceStop = 1; forceBusy = 1;
    steps(4);
    forceStop = 0; forceBusy = 0;
    steps(2);
    rst = 0;
    steps(3);
    // R2, R3: short stop, busy line held low while waiting
    busyInN = 0; stopIn = 1;
    steps(2);
    stopIn = 0;
    steps(6);
    busyInN = 1;
    steps(16);
    // R5: long stop keeps state 8
    stopIn = 1;
    steps(25);
    stopIn = 0;
    steps(16);
    // R7, R9: forced inputs alone
    forceStop = 1; steps(2);
    forceStop = 0; steps(9);
    forceBusy = 1; steps(3);
    forceBusy = 0; steps(3);
    // R6: follower mode
    workaroundEn = 0; stopIn = 1;
    steps(5);
    busyInN = 0; steps(3);
    stopIn = 0; busyInN = 1;
    steps(9);
    // R1: reset in the middle of a forced run
    workaroundEn = 1; stopIn = 1;
    steps(7);
    rst = 1; steps(2);
    rst = 0; stopIn = 0;
    steps(12);
    // Mixed random traffic (R2..R9)
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 9) == 0) stopIn = ~stopIn;
      if ($urandom_range(0, 3) == 0) busyInN = ~busyInN;
      forceStop = ($urandom_range(0, 29) == 0);
      forceBusy = ($urandom_range(0, 29) == 0);
      if ($urandom_range(0, 299) == 0) workaroundEn = ~workaroundEn;
      rst = ($urandom_range(0, 499) == 0);
      step();
    end
    rst = 0; stopIn = 0; forceStop = 0; forceBusy = 0;
    steps(20);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule